// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small bank of ownership tokens that two independent agents, a left port and a right port, use to guard shared resources. Each token is picked by a 3-bit index. A port touches the token bank only while its memory chip-select is inactive (high) and its token-select strobe is active (low). A port asks for a token by writing 0 on data bit 0 and gives it back by writing 1. A read tells a port whether it holds the indexed token.

A request that arrives while the other side holds the token is not lost. It is remembered as pending, and when the holder releases the token, ownership passes straight to the waiting side. The waiting side can withdraw its request by writing 1. If both ports request a free token on the same clock edge, the left port gets it and the right port's request becomes pending.

Top module: `sema_bank`

## Requirements
- R1: After reset every token is free, with no pending request, so both ports read all ones (9'h1FF) at every index.
- R2: A port accesses the bank only when its mem_cs_n is 1 and its tok_sel_n is 0. A write (we=1) outside that condition changes no token. Read data is all ones except during a decoded read (we=0), when it shows the state of the addressed token.
- R3: A decoded 0-write (wdata bit 0 = 0) to a free token makes that port the owner. The owner then reads all zeros and the other port reads all ones.
- R4: A 0-write from one port while the other port owns the token leaves ownership unchanged, and the owner keeps reading zeros.
- R5: When the owner writes 1 and the other port has a pending request, the other port becomes owner in the same edge and reads zeros from the next cycle on.
- R6: When the owner writes 1 and no request is pending, the token becomes free and both ports read ones.
- R7: If both ports 0-write the same free token on the same edge, the left port becomes owner and the right port's request is pending.
- R8: A 1-write by a port that does not own the token changes no ownership. If that port had a pending request on the token, the request is withdrawn, so a later release frees the token.
- R9: Only wdata bit 0 is used on writes. Read data replicates the token state on all nine bits: all zeros means the reading port owns the token.
- R10: The tokens are independent. An access at one index never changes another token.
- R11: A 0-write by the current owner leaves ownership and pending state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; token state updates on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| l_mem_cs_n | input | 1 | Left memory chip-select, active low; must be 1 for token access |
| l_tok_sel_n | input | 1 | Left token-select strobe, active low |
| l_we | input | 1 | Left write enable (1 = write, 0 = read) |
| l_addr | input | 3 | Left token index |
| l_wdata | input | 9 | Left write data; only bit 0 is used |
| l_rdata | output | 9 | Left read data, token state replicated on all bits |
| r_mem_cs_n | input | 1 | Right memory chip-select, active low; must be 1 for token access |
| r_tok_sel_n | input | 1 | Right token-select strobe, active low |
| r_we | input | 1 | Right write enable (1 = write, 0 = read) |
| r_addr | input | 3 | Right token index |
| r_wdata | input | 9 | Right write data; only bit 0 is used |
| r_rdata | output | 9 | Right read data, token state replicated on all bits |

## Verification
A write takes effect at the rising edge on which it is presented. Read data is a combinational view of the registered token state and the current index, so the result of a write shows up on a read one cycle later, with no extra latency. The bench drives inputs on the falling edge and compares both read buses with a behavioural model a short delay after that edge, before the next rising edge. It then advances the model at the rising edge with the same inputs. Release hand-offs, same-edge contests and withdrawals are therefore each checked exactly in the first cycle after the edge that caused them.

// File: rtl/sema_bank.sv
module sema_bank #(
  parameter int NTOK = 8,
  parameter int DW   = 9,
  localparam int AW  = $clog2(NTOK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_mem_cs_n,
  input  logic          l_tok_sel_n,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          r_mem_cs_n,
  input  logic          r_tok_sel_n,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata
);

  logic [NTOK-1:0] l_own, r_own, l_pend, r_pend;

  wire l_acc = l_mem_cs_n & ~l_tok_sel_n;
  wire r_acc = r_mem_cs_n & ~r_tok_sel_n;
  wire l_wr  = l_acc & l_we;
  wire r_wr  = r_acc & r_we;

  assign l_rdata = (l_acc & ~l_we) ? {DW{~l_own[l_addr]}} : {DW{1'b1}};
  assign r_rdata = (r_acc & ~r_we) ? {DW{~r_own[r_addr]}} : {DW{1'b1}};

  for (genvar t = 0; t < NTOK; t++) begin : g_tok
    wire lhit = l_wr & (l_addr == AW'(t));
    wire rhit = r_wr & (r_addr == AW'(t));
    wire lw0  = lhit & ~l_wdata[0];
    wire lw1  = lhit &  l_wdata[0];
    wire rw0  = rhit & ~r_wdata[0];
    wire rw1  = rhit &  r_wdata[0];

    logic lo_n, ro_n, lp_n, rp_n;
    logic lp_eff, rp_eff;

    always_comb begin
      lp_eff = (l_pend[t] | (lw0 & r_own[t])) & ~lw1;
      rp_eff = (r_pend[t] | (rw0 & l_own[t])) & ~rw1;
      lo_n = l_own[t];
      ro_n = r_own[t];
      lp_n = lp_eff;
      rp_n = rp_eff;
      if (!l_own[t] && !r_own[t]) begin
        lp_n = 1'b0;
        rp_n = 1'b0;
        if (lw0) begin
          lo_n = 1'b1;
          rp_n = rw0;
        end else if (rw0) begin
          ro_n = 1'b1;
        end
      end else if (l_own[t]) begin
        if (lw1) begin
          lo_n = 1'b0;
          ro_n = rp_eff;
          rp_n = 1'b0;
        end
      end else begin
        if (rw1) begin
          ro_n = 1'b0;
          lo_n = lp_eff;
          lp_n = 1'b0;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        l_own[t]  <= 1'b0;
        r_own[t]  <= 1'b0;
        l_pend[t] <= 1'b0;
        r_pend[t] <= 1'b0;
      end else begin
        l_own[t]  <= lo_n;
        r_own[t]  <= ro_n;
        l_pend[t] <= lp_n;
        r_pend[t] <= rp_n;
      end
    end
  end

endmodule

// File: rtl/sema_bank_chk.sv
module sema_bank_chk #(
  parameter int NTOK = 8,
  parameter int DW   = 9,
  localparam int AW  = $clog2(NTOK)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_mem_cs_n,
  input logic          l_tok_sel_n,
  input logic          l_we,
  input logic [AW-1:0] l_addr,
  input logic [DW-1:0] l_wdata,
  input logic [DW-1:0] l_rdata,
  input logic          r_mem_cs_n,
  input logic          r_tok_sel_n,
  input logic          r_we,
  input logic [AW-1:0] r_addr,
  input logic [DW-1:0] r_wdata,
  input logic [DW-1:0] r_rdata,
  input logic [NTOK-1:0] l_own,
  input logic [NTOK-1:0] r_own,
  input logic [NTOK-1:0] l_pend,
  input logic [NTOK-1:0] r_pend
);

  wire l_acc = l_mem_cs_n & ~l_tok_sel_n;
  wire r_acc = r_mem_cs_n & ~r_tok_sel_n;

  a_r3_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (l_own & r_own) == '0);

  a_r9_replicated: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));

  a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!(l_acc && l_we) && !(r_acc && r_we)) |=>
      ($stable(l_own) && $stable(r_own) && $stable(l_pend) && $stable(r_pend)));

  a_r4_holder_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (r_acc && r_we && !r_wdata[0] && l_own[r_addr] &&
     !(l_acc && l_we && l_addr == r_addr)) |=> l_own[$past(r_addr)]);

  a_r5_pending_not_owner: assert property (@(posedge clk) disable iff (!rst_n)
    ((l_own & l_pend) == '0) && ((r_own & r_pend) == '0));

  a_r7_left_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (l_acc && l_we && !l_wdata[0] && r_acc && r_we && !r_wdata[0] &&
     l_addr == r_addr && !l_own[l_addr] && !r_own[l_addr])
      |=> (l_own[$past(l_addr)] && r_pend[$past(l_addr)]));

  a_r2_read_view: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_acc && !l_we) |-> l_rdata == '1);

endmodule

bind sema_bank sema_bank_chk #(.NTOK(NTOK), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_mem_cs_n(l_mem_cs_n), .l_tok_sel_n(l_tok_sel_n), .l_we(l_we),
  .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
  .r_mem_cs_n(r_mem_cs_n), .r_tok_sel_n(r_tok_sel_n), .r_we(r_we),
  .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
  .l_own(l_own), .r_own(r_own), .l_pend(l_pend), .r_pend(r_pend)
);

// File: tb/sema_bank_test.sv
module sema_bank_test;
  localparam int NTOK = 8;
  localparam int DW   = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_mem_cs_n = 1'b1, l_tok_sel_n = 1'b1, l_we = 1'b0;
  logic r_mem_cs_n = 1'b1, r_tok_sel_n = 1'b1, r_we = 1'b0;
  logic [2:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;

  int checks = 0;
  int failures = 0;

  // model: 0 free, 1 left owns, 2 right owns
  int own [NTOK];
  bit lpend [NTOK];
  bit rpend [NTOK];

  always #4 clk = ~clk;

  sema_bank #(.NTOK(NTOK), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .l_mem_cs_n(l_mem_cs_n), .l_tok_sel_n(l_tok_sel_n), .l_we(l_we),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_mem_cs_n(r_mem_cs_n), .r_tok_sel_n(r_tok_sel_n), .r_we(r_we),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  function automatic logic [DW-1:0] exp_rd(bit left);
    bit acc, we;
    int a;
    acc = left ? (l_mem_cs_n && !l_tok_sel_n) : (r_mem_cs_n && !r_tok_sel_n);
    we  = left ? l_we : r_we;
    a   = left ? int'(l_addr) : int'(r_addr);
    if (!acc || we) return '1;
    return (own[a] == (left ? 1 : 2)) ? '0 : '1;
  endfunction

  task automatic compare(string tag);
    logic [DW-1:0] el, er;
    el = exp_rd(1'b1);
    er = exp_rd(1'b0);
    checks++;
    if (l_rdata !== el) begin
      failures++;
      $display("FAIL %s left rdata actual=%h expected=%h t=%0t", tag, l_rdata, el, $time);
    end
    checks++;
    if (r_rdata !== er) begin
      failures++;
      $display("FAIL %s right rdata actual=%h expected=%h t=%0t", tag, r_rdata, er, $time);
    end
  endtask

  task automatic model_edge();
    bit lacc, racc;
    lacc = l_mem_cs_n && !l_tok_sel_n && l_we;
    racc = r_mem_cs_n && !r_tok_sel_n && r_we;
    for (int t = 0; t < NTOK; t++) begin
      bit lw0, lw1, rw0, rw1;
      lw0 = lacc && int'(l_addr) == t && !l_wdata[0];
      lw1 = lacc && int'(l_addr) == t &&  l_wdata[0];
      rw0 = racc && int'(r_addr) == t && !r_wdata[0];
      rw1 = racc && int'(r_addr) == t &&  r_wdata[0];
      if (own[t] == 0) begin
        if (lw0) begin own[t] = 1; rpend[t] = rw0; end
        else if (rw0) own[t] = 2;
      end else if (own[t] == 1) begin
        if (rw0) rpend[t] = 1;
        if (rw1) rpend[t] = 0;
        if (lw1) begin own[t] = rpend[t] ? 2 : 0; rpend[t] = 0; end
      end else begin
        if (lw0) lpend[t] = 1;
        if (lw1) lpend[t] = 0;
        if (rw1) begin own[t] = lpend[t] ? 1 : 0; lpend[t] = 0; end
      end
    end
  endtask

  // one cycle: drive on falling edge, compare, advance model at rising edge
  task automatic cyc(string tag,
                     bit lcs_n, bit lsel_n, bit lwe, int la, logic [DW-1:0] ld,
                     bit rcs_n, bit rsel_n, bit rwe, int ra, logic [DW-1:0] rd);
    @(negedge clk);
    l_mem_cs_n = lcs_n; l_tok_sel_n = lsel_n; l_we = lwe; l_addr = 3'(la); l_wdata = ld;
    r_mem_cs_n = rcs_n; r_tok_sel_n = rsel_n; r_we = rwe; r_addr = 3'(ra); r_wdata = rd;
    #1;
    compare(tag);
    @(posedge clk);
    model_edge();
  endtask

  task automatic lwr(string tag, int a, logic [DW-1:0] d);
    cyc(tag, 1, 0, 1, a, d, 1, 1, 0, 0, '0);
  endtask
  task automatic rwr(string tag, int a, logic [DW-1:0] d);
    cyc(tag, 1, 1, 0, 0, '0, 1, 0, 1, a, d);
  endtask
  task automatic rdboth(string tag, int a);
    cyc(tag, 1, 0, 0, a, '0, 1, 0, 0, a, '0);
  endtask

  initial begin
    for (int t = 0; t < NTOK; t++) begin own[t] = 0; lpend[t] = 0; rpend[t] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int t = 0; t < NTOK; t++) rdboth("R1 reset free", t);

    lwr("R3 left takes", 0, 9'h000);
    rdboth("R3 owner reads zeros", 0);
    rwr("R4 right blocked", 0, 9'h000);
    rdboth("R4 holder kept", 0);
    lwr("R11 owner rewrite", 0, 9'h000);
    rdboth("R11 unchanged", 0);
    lwr("R5 release to pending", 0, 9'h001);
    rdboth("R5 right granted", 0);
    rwr("R6 right releases", 0, 9'h001);
    rdboth("R6 free again", 0);

    cyc("R7 contest", 1, 0, 1, 3, 9'h000, 1, 0, 1, 3, 9'h000);
    rdboth("R7 left wins", 3);
    lwr("R7 release", 3, 9'h001);
    rdboth("R7 right had pending", 3);
    rwr("R7 cleanup", 3, 9'h001);

    lwr("R8 non-owner 1-write on free", 5, 9'h001);
    rdboth("R8 still free", 5);
    rwr("R8 take", 5, 9'h000);
    lwr("R8 left blocked", 5, 9'h000);
    lwr("R8 left withdraws", 5, 9'h001);
    rdboth("R8 right still owns", 5);
    rwr("R8 release no pending", 5, 9'h001);
    rdboth("R8 free after withdraw", 5);

    cyc("R2 mem selected", 0, 0, 1, 2, 9'h000, 1, 1, 0, 0, '0);
    cyc("R2 strobe off", 1, 1, 1, 2, 9'h000, 1, 1, 0, 0, '0);
    rdboth("R2 no effect", 2);
    lwr("R2 take", 2, 9'h000);
    cyc("R2 owner not decoded reads ones", 0, 0, 0, 2, '0, 1, 1, 0, 2, '0);
    cyc("R2 write cycle reads ones", 1, 0, 1, 2, 9'h000, 1, 0, 1, 6, 9'h001);

    rwr("R9 upper bits ignored", 7, 9'h1FE);
    rdboth("R9 replicated zeros", 7);
    rwr("R9 release with d0", 7, 9'h001);
    rdboth("R9 free", 7);

    lwr("R10 take 1", 1, 9'h000);
    for (int t = 0; t < NTOK; t++) rdboth("R10 independence", t);

    // mixed traffic, compared every cycle
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cyc("R5 R6 R7 R8 R10 mixed",
            lfsr[0] | lfsr[1], lfsr[2] & lfsr[3], lfsr[4], int'(lfsr[6:5]), {8'hA5 ^ lfsr[14:7], lfsr[15]},
            lfsr[8] | lfsr[9], lfsr[10] & lfsr[11], lfsr[12], int'(lfsr[14:13]), {lfsr[8:1], lfsr[3]});
      end
    end

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule